// File: doc/BRIEF.md
# Staggered Column Bias Sequencer

This block moves the analog bias of a pixel array's columns between a nominal operating point and a low-current standby point. It does so one column at a time, in response to an external pulse request, so that the supply current of the array rises and falls in small steps rather than as one large transient. The acquisition window is very short against a long idle period, so the array spends most of the cycle in standby. During that time the block can also cut the analog supply of each column completely.

The columns that run at nominal bias always form a contiguous group starting at column 0. While the request is high, the group grows upward one column per step. While the request is low, it shrinks from its highest column downward. The spacing between two consecutive column events is a programmable number of clock cycles. A column with its supply cut gets its supply back in one step and its bias raised in a later step. On the way down, its bias drops first and its supply is cut in a later step. A status output reports when the whole array is at nominal bias.

Top module: `col_power_sequencer`

## Requirements
- R1: During and right after reset, every bias_nom_o bit is 0, every supply_off_o bit is 0 and all_on_o is 0.
- R2: bias_nom_o is always a thermometer code from bit 0 (bit c = 1 means column c is at nominal bias). While pulse_req_i is high, the next column to become nominal is the lowest one that is not.
- R3: While pulse_req_i is low, the column that leaves nominal bias is the highest nominal one.
- R4: A pending event takes effect on the clock edge at which it has been pending for step_cycles_i+1 edges. Successive events of a ramp are therefore step_cycles_i+1 cycles apart, and the first event comes step_cycles_i+1 edges after the request change is sampled.
- R5: No more than one bit of bias_nom_o and supply_off_o together changes on any clock edge.
- R6: A column whose supply is cut (supply_off_o bit = 1) gets its supply restored in one event, and its bias becomes nominal in a later event.
- R7: With pwroff_en_i high and the request low, the supply of a column is cut only in an event after its bias has left nominal. Cuts go from the highest powered column down, until all supply_off_o bits are 1.
- R8: With pwroff_en_i low and the request low, no supply is cut. Columns whose supply is cut get it restored one per event, from the lowest column upward.
- R9: A request change in the middle of a ramp reverses the ramp from the current column, without first finishing the ramp or returning to an end state.
- R10: all_on_o rises one cycle after the last column becomes nominal. It falls on the same edge at which the first column leaves nominal.
- R11: Once the outputs have reached the state the request asks for, they hold steady for as long as the inputs do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_req_i | input | 1 | External request: 1 asks for nominal bias on all columns, 0 for standby |
| step_cycles_i | input | STEP_W | Spacing between column events, minus one, in clock cycles |
| pwroff_en_i | input | 1 | Allows the analog supply to be cut during standby |
| bias_nom_o | output | NUM_COLS | Per-column bias select, 1 = nominal |
| supply_off_o | output | NUM_COLS | Per-column analog supply cut, 1 = off |
| all_on_o | output | 1 | Whole array at nominal bias |

## Verification
The bench builds the block with four columns and a three-bit spacing field. With these values a complete ramp, including the interleaved supply and bias events, takes only a few dozen cycles, so the top column, the all-on flag and both ends of every ramp are reached many times. The narrow spacing field also lets the bench run zero spacing and several small spacings, and so compare one-event-per-cycle ramps against ramps with gaps. Reversals are applied at partial ramps in both directions, and the power-cut enable is switched both with the array active and with it idle.

// File: rtl/col_pwr_pkg.sv
package col_pwr_pkg;

   // one event a ramp may take on a step tick
   typedef enum logic [2:0] {
      EV_NONE     = 3'd0,
      EV_BIAS_UP  = 3'd1,
      EV_BIAS_DN  = 3'd2,
      EV_SUP_ON   = 3'd3,
      EV_SUP_OFF  = 3'd4
   } col_event_e;

endpackage

// File: rtl/cps_step_timer.sv
module cps_step_timer #(
   parameter int STEP_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              busy_i,
   input  logic [STEP_W-1:0] step_i,
   output logic              tick_o
);

   logic [STEP_W-1:0] wait_q;

   // a tick fires when the pending event has waited long enough
   assign tick_o = busy_i && (wait_q >= step_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         wait_q <= '0;
      else if (!busy_i || tick_o)
         wait_q <= '0;
      else
         wait_q <= wait_q + 1'b1;
   end

   // R4
   tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && step_i != '0) |=> (!tick_o || $changed(step_i)));

   // R4
   wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && $stable(step_i) && !$past(tick_o) && $past(busy_i)) |-> (wait_q <= step_i));

endmodule

// File: rtl/cps_ramp_ctrl.sv
module cps_ramp_ctrl
   import col_pwr_pkg::*;
#(
   parameter int NUM_COLS     = 16,
   parameter int CNT_W        = 5,
   parameter bit ALLOW_PWROFF = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_i,
   input  logic             pwroff_en_i,
   input  logic             tick_i,
   output logic             busy_o,
   output logic             full_hold_o,
   output logic [CNT_W-1:0] nom_cnt_o,
   output logic [CNT_W-1:0] pwr_cnt_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_COLS);

   // nom_q: columns [0, nom_q) at nominal bias
   // pwr_q: columns [0, pwr_q) with supply present
   logic [CNT_W-1:0] nom_q, pwr_q;
   logic             cut_ok;
   col_event_e       ev;

   generate
      if (ALLOW_PWROFF) begin : g_cut
         assign cut_ok = pwroff_en_i;
      end else begin : g_nocut
         assign cut_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      ev = EV_NONE;
      if (req_i) begin
         if (nom_q != LAST)
            ev = (pwr_q > nom_q) ? EV_BIAS_UP : EV_SUP_ON;
      end else if (cut_ok && (pwr_q > nom_q)) begin
         ev = EV_SUP_OFF;
      end else if (nom_q != '0) begin
         ev = EV_BIAS_DN;
      end else if (!cut_ok && (pwr_q != LAST)) begin
         ev = EV_SUP_ON;
      end
   end

   assign busy_o      = (ev != EV_NONE);
   assign full_hold_o = (nom_q == LAST) && !(tick_i && ev == EV_BIAS_DN);
   assign nom_cnt_o   = nom_q;
   assign pwr_cnt_o   = pwr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         nom_q <= '0;
         pwr_q <= LAST;
      end else if (tick_i) begin
         unique case (ev)
            EV_BIAS_UP: nom_q <= nom_q + 1'b1;
            EV_BIAS_DN: nom_q <= nom_q - 1'b1;
            EV_SUP_ON:  pwr_q <= pwr_q + 1'b1;
            EV_SUP_OFF: pwr_q <= pwr_q - 1'b1;
            default:    ;
         endcase
      end
   end

   // R6
   order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nom_q <= pwr_q) && (pwr_q <= LAST));

   // R11
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && $stable(req_i) && $stable(pwroff_en_i)) |=> ($stable(nom_q) && $stable(pwr_q)));

endmodule

// File: rtl/cps_col_decode.sv
module cps_col_decode #(
   parameter int NUM_COLS = 16,
   parameter int CNT_W    = 5
) (
   input  logic [CNT_W-1:0]    nom_cnt_i,
   input  logic [CNT_W-1:0]    pwr_cnt_i,
   output logic [NUM_COLS-1:0] bias_nom_o,
   output logic [NUM_COLS-1:0] supply_off_o
);

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      assign bias_nom_o[c]   = (CNT_W'(c) < nom_cnt_i);
      assign supply_off_o[c] = !(CNT_W'(c) < pwr_cnt_i);
   end

   // R6
   always_comb begin
      overlap_chk: assert ((bias_nom_o & supply_off_o) == '0);
   end

endmodule

// File: rtl/col_power_sequencer.sv
module col_power_sequencer #(
   parameter int NUM_COLS     = 16,
   parameter int STEP_W       = 8,
   parameter bit ALLOW_PWROFF = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                pulse_req_i,
   input  logic [STEP_W-1:0]   step_cycles_i,
   input  logic                pwroff_en_i,
   output logic [NUM_COLS-1:0] bias_nom_o,
   output logic [NUM_COLS-1:0] supply_off_o,
   output logic                all_on_o
);

   localparam int CNT_W = $clog2(NUM_COLS + 1);

   if (NUM_COLS < 2) begin : g_bad_cols
      $error("col_power_sequencer: NUM_COLS must be at least 2");
   end
   if (STEP_W < 1 || STEP_W > 24) begin : g_bad_step
      $error("col_power_sequencer: STEP_W must lie in 1..24");
   end

   logic             busy, tick, full_hold;
   logic [CNT_W-1:0] nom_cnt, pwr_cnt;
   logic             all_on_q;

   cps_step_timer #(.STEP_W(STEP_W)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .busy_i (busy),
      .step_i (step_cycles_i),
      .tick_o (tick)
   );

   cps_ramp_ctrl #(
      .NUM_COLS    (NUM_COLS),
      .CNT_W       (CNT_W),
      .ALLOW_PWROFF(ALLOW_PWROFF)
   ) u_ramp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (pulse_req_i),
      .pwroff_en_i (pwroff_en_i),
      .tick_i      (tick),
      .busy_o      (busy),
      .full_hold_o (full_hold),
      .nom_cnt_o   (nom_cnt),
      .pwr_cnt_o   (pwr_cnt)
   );

   cps_col_decode #(.NUM_COLS(NUM_COLS), .CNT_W(CNT_W)) u_dec (
      .nom_cnt_i    (nom_cnt),
      .pwr_cnt_i    (pwr_cnt),
      .bias_nom_o   (bias_nom_o),
      .supply_off_o (supply_off_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) all_on_q <= 1'b0;
      else         all_on_q <= full_hold;
   end
   assign all_on_o = all_on_q;

   // R5
   one_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({bias_nom_o, supply_off_o} ^ $past({bias_nom_o, supply_off_o})) <= 1);

   // R2
   thermo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (({1'b0, bias_nom_o} + 1'b1) & {1'b0, bias_nom_o}) == '0);

   // R6
   bias_after_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bias_nom_o & ~$past(bias_nom_o) & $past(supply_off_o)) == '0);

   // R7
   cut_after_bias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (supply_off_o & ~$past(supply_off_o) & $past(bias_nom_o)) == '0);

   // R10
   all_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(all_on_o) |-> (&$past(bias_nom_o)));

   // R10
   all_on_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      all_on_o |-> (&bias_nom_o));

endmodule

// File: tb/col_power_sequencer_tb.sv
module col_power_sequencer_tb_top;

   localparam int  N      = 4;
   localparam int  SW     = 3;
   localparam time CLK_PS = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          pen = 1'b0;
   logic [SW-1:0] step = '0;
   logic [N-1:0]  bias, off;
   logic          allon;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PS/2) clk = ~clk;

   col_power_sequencer #(.NUM_COLS(N), .STEP_W(SW), .ALLOW_PWROFF(1'b1)) dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .pulse_req_i   (req),
      .step_cycles_i (step),
      .pwroff_en_i   (pen),
      .bias_nom_o    (bias),
      .supply_off_o  (off),
      .all_on_o      (allon)
   );

   // ---------------- expected-item driver (model from the requirements)
   logic [2*N:0] exp_q[$];
   int m_nom, m_pwr, m_wait, m_ev, m_old;
   logic m_allon;

   always @(posedge clk) begin
      logic [2*N:0] item;
      if (!rst_n) begin
         m_nom = 0; m_pwr = N; m_wait = 0; m_allon = 1'b0;   // R1
      end else begin
         m_ev = 0;
         if (req) begin
            if (m_nom < N) m_ev = (m_pwr > m_nom) ? 1 : 3;    // R2, R6
         end else if (pen && m_pwr > m_nom) m_ev = 4;        // R7
         else if (m_nom > 0) m_ev = 2;                       // R3
         else if (!pen && m_pwr < N) m_ev = 3;               // R8
         m_old = m_nom;
         if (m_ev != 0) begin
            if (m_wait >= int'(step)) begin                  // R4
               case (m_ev)
                  1: m_nom++;
                  2: m_nom--;
                  3: m_pwr++;
                  default: m_pwr--;
               endcase
               m_wait = 0;
            end else m_wait++;
         end else m_wait = 0;
         m_allon = (m_old == N) && (m_nom == N);             // R10
      end
      for (int c = 0; c < N; c++) begin
         item[c]     = (c < m_nom);
         item[N + c] = (c >= m_pwr);
      end
      item[2*N] = m_allon;
      exp_q.push_back(item);
   end

   // ---------------- monitor
   logic [2*N-1:0] prev_obs = '0;
   bit             have_prev = 1'b0;

   always @(negedge clk) begin
      logic [2*N:0] e;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         n_chk++;
         if (bias !== e[N-1:0]) begin
            n_fail++;
            $display("FAIL R2 bias_nom actual=%b expected=%b", bias, e[N-1:0]);
         end else if (off !== e[2*N-1:N]) begin
            n_fail++;
            $display("FAIL R7 supply_off actual=%b expected=%b", off, e[2*N-1:N]);
         end else if (allon !== e[2*N]) begin
            n_fail++;
            $display("FAIL R10 all_on actual=%b expected=%b", allon, e[2*N]);
         end
      end
      if (rst_n && have_prev) begin
         n_chk++;   // R5
         if ($countones({off, bias} ^ prev_obs) > 1) begin
            n_fail++;
            $display("FAIL R5 changed bits actual=%0d expected<=1",
                     $countones({off, bias} ^ prev_obs));
         end
      end
      prev_obs  = {off, bias};
      have_prev = rst_n;
   end

   // ---------------- directed helpers
   task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
      end
   endtask

   task automatic next_change(output int cyc);
      logic [2*N-1:0] start;
      start = {off, bias};
      cyc = 0;
      while ({off, bias} == start && cyc < 400) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus
   initial begin
      int cyc;
      settle(3);
      // R1 reset state
      check("R1 bias", 32'(bias), 32'h0);
      check("R1 off", 32'(off), 32'h0);
      check("R1 all_on", 32'(allon), 32'h0);
      rst_n = 1'b1;
      settle(2);
      check("R1 after release", 32'({allon, off, bias}), 32'h0);

      // R2 R4: ramp up with spacing 3 cycles
      step = 3'd2; req = 1'b1;
      next_change(cyc);
      check("R4 first delay", 32'(cyc), 32'd3);
      check("R2 first column", 32'(bias), 32'b0001);
      next_change(cyc);
      check("R4 spacing", 32'(cyc), 32'd3);
      check("R2 second column", 32'(bias), 32'b0011);
      next_change(cyc);
      next_change(cyc);
      check("R2 full", 32'(bias), 32'b1111);
      check("R10 all_on not yet", 32'(allon), 32'd0);
      settle(1);
      check("R10 all_on rises", 32'(allon), 32'd1);
      // R11 settled
      settle(12);
      check("R11 hold", 32'({allon, off, bias}), 32'h10F);

      // R3 turn-off from the top
      req = 1'b0;
      next_change(cyc);
      check("R3 top column leaves", 32'(bias), 32'b0111);
      check("R10 all_on falls", 32'(allon), 32'd0);
      // R9 reverse mid-ramp
      req = 1'b1;
      next_change(cyc);
      check("R9 reversed up", 32'(bias), 32'b1111);

      // R7 ramp down with supply cut, spacing 1 cycle
      step = 3'd0; pen = 1'b1; req = 1'b0;
      next_change(cyc);
      check("R4 zero spacing", 32'(cyc), 32'd1);
      next_change(cyc);
      check("R7 cut after bias", 32'({off, bias}), 32'b1000_0111);
      settle(30);
      check("R7 all cut", 32'({off, bias}), 32'b1111_0000);

      // R6 ramp up from cut supply
      step = 3'd1; req = 1'b1;
      next_change(cyc);
      check("R6 supply first", 32'({off, bias}), 32'b1110_0000);
      next_change(cyc);
      check("R6 bias second", 32'({off, bias}), 32'b1110_0001);
      check("R4 spacing two", 32'(cyc), 32'd2);
      settle(30);
      check("R6 all on", 32'({allon, off, bias}), 32'h10F);

      // R8 cut disabled while idle restores supply from the bottom
      step = 3'd0; req = 1'b0;
      settle(30);
      check("R7 idle cut", 32'({off, bias}), 32'b1111_0000);
      pen = 1'b0;
      next_change(cyc);
      check("R8 lowest restored first", 32'({off, bias}), 32'b1110_0000);
      settle(20);
      check("R8 all restored", 32'({off, bias}), 32'h00);

      // R9 reverse a partial up-ramp
      step = 3'd3; req = 1'b1;
      next_change(cyc);
      next_change(cyc);
      check("R9 partial", 32'(bias), 32'b0011);
      req = 1'b0;
      next_change(cyc);
      check("R9 reversed down", 32'(bias), 32'b0001);
      settle(20);
      check("R11 idle", 32'({allon, off, bias}), 32'h0);

      done = 1'b1;
      settle(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule